// File: doc/BRIEF.md
# Serial Command Frame Port

This block is the digital front end of a serial-controlled multi-channel switch. A host drives a chip select, a serial clock and a data line. The block takes in a command word that sets two things for each channel: whether its output is on, and whether its open-load sense current is enabled. While the command shifts in, the block returns a status word that holds one fault flag per channel. The serial pins are asynchronous to the block's system clock. They pass through synchronizers, and their edges are detected in the system clock domain.

The shift path is a plain first-in first-out register as wide as the word. The block can therefore sit in a daisy chain: each device forwards what it received one word earlier, and it keeps only the last word it saw. A received word is committed only when chip select rises. It is committed only if the number of serial clock pulses in that frame is two channel groups plus any whole number of further groups. For eight channels that means 16, 24, 32 and so on. A frame of any other length leaves the command register as it was. A sleep request clears the register, and so does a reset. A sleep request also voids any frame that is open at that moment.

Top module: `serial_cmd_port`

## Requirements
- R1: The word is sent MSB first, so the first bit received ends up in bit 15. After a commit, `ol_en_o[i]` equals word bit 8+i and `out_on_o[i]` equals word bit i, where i=0 is channel 1.
- R2: The data line is captured on each falling serial clock edge. The data output changes on each rising edge, and the first rising edge presents the status MSB.
- R3: While chip select is high, the block ignores the serial clock and data line, holds `sdo_oe_o` low and holds `sdo_o` low.
- R4: The command register does not change during shifting. It is updated only when chip select rises.
- R5: A frame is committed only if it has 16 + 8k serial clock pulses. Frames of 8, 15, 17 or 23 pulses, and any other length, leave both outputs unchanged.
- R6: The returned status word is eight zeros followed by `fault_i[7]` down to `fault_i[0]`. It is sampled when chip select falls.
- R7: After the first 16 rising edges, the data output repeats the bits received 16 pulses earlier. In a 32-pulse frame, the second half returned equals the first half sent, and the last 16 bits sent are the ones committed.
- R8: Reset clears both outputs to zero. A sleep request clears them on the next clock and voids the open frame, so the following chip select rise commits nothing.
- R9: Frames longer than the pulse counter's range are still judged correctly: a 264-pulse frame is committed and a 265-pulse frame is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Sleep request; clears command, voids the open frame |
| csn_i | input | 1 | Chip select, active low, asynchronous |
| sck_i | input | 1 | Serial clock, idle low, asynchronous |
| sdi_i | input | 1 | Serial data in |
| fault_i | input | NUM_CH | Per-channel fault flags (bit 0 = channel 1) |
| sdo_o | output | 1 | Serial data out, low when not enabled |
| sdo_oe_o | output | 1 | Data out enable, high while chip select is low |
| out_on_o | output | NUM_CH | Output-on bits of the command register |
| ol_en_o | output | NUM_CH | Open-load current enable bits of the command register |

## Verification
The hardest state to reach from the ports is a long frame that has run past the range of any plain pulse counter. Its legality then depends only on its length modulo one group. The stimulus drives 264-pulse and 265-pulse frames and checks the register after each. A second hard case is a sleep request that arrives after a legal number of pulses but before chip select rises. The bench holds chip select low across the sleep pulse and only then closes the frame. A behavioural model runs the same synchronizer latency with queues and is compared on every clock.

// File: rtl/scp_pkg.sv
package scp_pkg;

   typedef struct packed {
      logic cs_n;
      logic sck;
      logic sdi;
   } pin_t;

   localparam pin_t PIN_IDLE = '{cs_n: 1'b1, sck: 1'b0, sdi: 1'b0};

   localparam int GRP_NEED = 2;

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
   parameter int          WIDTH   = 3,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] in_i,
   output logic [WIDTH-1:0] out_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign out_o = in_i;
      end else begin : g_chain
         logic [WIDTH-1:0] stg_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
            end else begin
               stg_q[0] <= in_i;
               for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
            end
         end
         assign out_o = stg_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/scp_frame_cnt.sv
module scp_frame_cnt #(
   parameter int NUM_CH = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic pulse_i,
   output logic ok_o
);

   localparam int LO_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam logic [LO_W-1:0] LO_LAST = LO_W'(NUM_CH - 1);
   localparam logic [1:0]      GRP_SAT = 2'(scp_pkg::GRP_NEED);

   logic [LO_W-1:0] lo_q;
   logic [1:0]      grp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q  <= '0;
         grp_q <= '0;
      end else if (clear_i) begin
         lo_q  <= '0;
         grp_q <= '0;
      end else if (pulse_i) begin
         if (lo_q == LO_LAST) begin
            lo_q <= '0;
            if (grp_q != GRP_SAT) grp_q <= grp_q + 2'd1;
         end else begin
            lo_q <= lo_q + LO_W'(1);
         end
      end
   end

   assign ok_o = (grp_q == GRP_SAT) && (lo_q == '0);

   AST_OK_ONLY_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ok_o) |-> $past(pulse_i)); // R5

endmodule

// File: rtl/scp_shifter.sv
module scp_shifter #(
   parameter int NUM_CH = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  act_i,
   input  logic                  load_i,
   input  logic                  rise_i,
   input  logic                  fall_i,
   input  logic                  sdi_i,
   input  logic [NUM_CH-1:0]     fault_i,
   output logic [2*NUM_CH-1:0]   word_o,
   output logic                  dout_o
);

   localparam int W = 2 * NUM_CH;

   logic [W-1:0] sr_q;
   logic         dout_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q   <= '0;
         dout_q <= 1'b0;
      end else if (load_i) begin
         sr_q   <= {{NUM_CH{1'b0}}, fault_i};
         dout_q <= 1'b0;
      end else if (rise_i) begin
         dout_q <= sr_q[W-1];
         sr_q   <= {sr_q[W-2:0], 1'b0};
      end else if (fall_i) begin
         sr_q[0] <= sdi_i;
      end
   end

   assign word_o = sr_q;
   assign dout_o = dout_q;

   AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!act_i) |-> $stable(sr_q)); // R3

   AST_STATUS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(load_i) |-> (sr_q[W-1 -: NUM_CH] == '0) && (sr_q[NUM_CH-1:0] == $past(fault_i))); // R6

endmodule

// File: rtl/scp_cmd_reg.sv
module scp_cmd_reg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sleep_i,
   input  logic         apply_i,
   input  logic [W-1:0] word_i,
   output logic [W-1:0] cmd_o
);

   logic [W-1:0] cmd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cmd_q <= '0;
      else if (sleep_i) cmd_q <= '0;
      else if (apply_i) cmd_q <= word_i;
   end

   assign cmd_o = cmd_q;

   AST_CMD_ONLY_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cmd_q) |-> ($past(apply_i) || $past(sleep_i))); // R4

   AST_SLEEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i |=> (cmd_q == '0)); // R8

endmodule

// File: rtl/serial_cmd_port.sv
module serial_cmd_port
   import scp_pkg::*;
#(
   parameter int NUM_CH      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep_i,
   input  logic              csn_i,
   input  logic              sck_i,
   input  logic              sdi_i,
   input  logic [NUM_CH-1:0] fault_i,
   output logic              sdo_o,
   output logic              sdo_oe_o,
   output logic [NUM_CH-1:0] out_on_o,
   output logic [NUM_CH-1:0] ol_en_o
);

   localparam int WORD_W = 2 * NUM_CH;

   generate
      if (NUM_CH < 2 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_ch
         $error("NUM_CH must be a power of two of at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic [2:0] pins_raw;
   pin_t       pins_s;
   pin_t       pins_d;

   scp_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .in_i  ({csn_i, sck_i, sdi_i}),
      .out_o (pins_raw)
   );

   assign pins_s = pin_t'(pins_raw);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pins_d <= PIN_IDLE;
      else        pins_d <= pins_s;
   end

   logic act, cs_fall, cs_rise, sck_rise, sck_fall;

   assign act      = ~pins_s.cs_n;
   assign cs_fall  =  pins_d.cs_n & ~pins_s.cs_n;
   assign cs_rise  = ~pins_d.cs_n &  pins_s.cs_n;
   assign sck_rise = act & ~pins_d.sck &  pins_s.sck;
   assign sck_fall = act &  pins_d.sck & ~pins_s.sck;

   logic              frame_ok;
   logic [WORD_W-1:0] rx_word;
   logic [WORD_W-1:0] cmd;
   logic              dout;

   scp_frame_cnt #(.NUM_CH(NUM_CH)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (sleep_i | cs_fall),
      .pulse_i (sck_fall),
      .ok_o    (frame_ok)
   );

   scp_shifter #(.NUM_CH(NUM_CH)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .act_i   (act),
      .load_i  (cs_fall),
      .rise_i  (sck_rise),
      .fall_i  (sck_fall),
      .sdi_i   (pins_s.sdi),
      .fault_i (fault_i),
      .word_o  (rx_word),
      .dout_o  (dout)
   );

   scp_cmd_reg #(.W(WORD_W)) u_cmd (
      .clk     (clk),
      .rst_n   (rst_n),
      .sleep_i (sleep_i),
      .apply_i (cs_rise & frame_ok),
      .word_i  (rx_word),
      .cmd_o   (cmd)
   );

   assign sdo_oe_o = act;
   assign sdo_o    = act & dout;
   assign ol_en_o  = cmd[WORD_W-1:NUM_CH];
   assign out_on_o = cmd[NUM_CH-1:0];

   AST_DO_RELEASED_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cs_rise) |-> !sdo_oe_o && !sdo_o); // R3

endmodule

// File: tb/serial_cmd_port_tb.sv
module serial_cmd_port_tb;

   localparam int CLK_PERIOD = 10;
   localparam int HP         = 5;
   localparam int WD_LIMIT   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sleep_i = 1'b0;
   logic       csn_i = 1'b1;
   logic       sck_i = 1'b0;
   logic       sdi_i = 1'b0;
   logic [7:0] fault_i = 8'h00;
   logic       sdo_o, sdo_oe_o;
   logic [7:0] out_on_o, ol_en_o;

   int    vectors = 0;
   int    misses  = 0;
   int    cycles  = 0;
   string tag     = "R8";

   always #(CLK_PERIOD/2) clk = ~clk;

   serial_cmd_port u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .sleep_i  (sleep_i),
      .csn_i    (csn_i),
      .sck_i    (sck_i),
      .sdi_i    (sdi_i),
      .fault_i  (fault_i),
      .sdo_o    (sdo_o),
      .sdo_oe_o (sdo_oe_o),
      .out_on_o (out_on_o),
      .ol_en_o  (ol_en_o)
   );

   // behavioural reference: pins seen through two sync stages plus edge compare
   logic [2:0]  hist [$];
   bit          mq [$];
   int          mcnt = 0;
   logic [15:0] mcmd = '0;
   logic        mdout = 1'b0;

   always @(posedge clk) begin
      logic [2:0] pv, cu;
      bit csf, csr, act, skr, skf, ok;
      if (!rst_n) begin
         hist = {3'b100, 3'b100, 3'b100, 3'b100};
         mq.delete();
         mcnt = 0; mcmd = '0; mdout = 1'b0;
      end else begin
         hist.push_back({csn_i, sck_i, sdi_i});
         void'(hist.pop_front());
         pv  = hist[0];
         cu  = hist[1];
         csf = pv[2] && !cu[2];
         csr = !pv[2] && cu[2];
         act = !cu[2];
         skr = act && !pv[1] && cu[1];
         skf = act && pv[1] && !cu[1];
         ok  = (mcnt >= 16) && (mcnt % 8 == 0);
         if (sleep_i) mcmd = '0;
         else if (csr && ok && mq.size() >= 16)
            for (int i = 0; i < 16; i++) mcmd[15-i] = mq[mq.size()-16+i];
         if (sleep_i || csf) mcnt = 0;
         else if (skf) mcnt++;
         if (csf) begin
            mq.delete();
            for (int i = 0; i < 8; i++) mq.push_back(1'b0);
            for (int i = 7; i >= 0; i--) mq.push_back(fault_i[i]);
            mdout = 1'b0;
         end else if (skr) begin
            mdout = (mq.size() > 0) ? mq.pop_front() : 1'b0;
         end else if (skf) begin
            mq.push_back(cu[0]);
         end
      end
   end

   always @(negedge clk) begin
      logic eoe, edo;
      cycles++;
      if (rst_n && hist.size() == 4) begin
         eoe = !hist[2][2];
         edo = eoe && mdout;
         vectors++;
         if ({ol_en_o, out_on_o} !== mcmd || sdo_oe_o !== eoe || sdo_o !== edo) begin
            misses++;
            $display("FAIL %s cycle %0d: act cmd=%h oe=%b do=%b exp cmd=%h oe=%b do=%b",
                     tag, cycles, {ol_en_o, out_on_o}, sdo_oe_o, sdo_o, mcmd, eoe, edo);
         end
      end
      if (cycles > WD_LIMIT) begin
         misses++;
         $display("FAIL watchdog act cycles=%0d exp <=%0d", cycles, WD_LIMIT);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s %s: act %h exp %h", req, what, act, exp);
      end
   endtask

   task automatic send(input logic [511:0] bits, input int n, input bit close, output logic [511:0] got);
      got = '0;
      csn_i = 1'b0;
      tick(HP);
      for (int i = n - 1; i >= 0; i--) begin
         sdi_i = bits[i];
         sck_i = 1'b1;
         tick(HP);
         got[i] = sdo_o;
         sck_i = 1'b0;
         tick(HP);
      end
      if (close) begin
         csn_i = 1'b1;
         tick(2 * HP);
      end
   endtask

   logic [511:0] got;
   logic [511:0] bits;
   logic [15:0]  exp_cmd;

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(2);
      tag = "R8";
      chk({ol_en_o, out_on_o}, 16'h0000, "R8", "command after reset");
      chk(sdo_oe_o, 1'b0, "R8", "data out enable after reset");

      // basic 16-bit frame: mapping, status word, edge behaviour
      tag = "R1";
      fault_i = 8'h3C;
      send(512'h0A55A, 16, 1'b1, got);
      chk(got[15:0], 16'h003C, "R6", "status word returned");
      chk(got[15:8], 8'h00, "R2", "first rising edges present zero head");
      chk(ol_en_o, 8'hA5, "R1", "open-load enables from bits 15..8");
      chk(out_on_o, 8'h5A, "R1", "output bits from bits 7..0");
      exp_cmd = 16'hA55A;

      // no commit while chip select stays low
      tag = "R4";
      fault_i = 8'hFF;
      send(512'h01248, 16, 1'b0, got);
      chk({ol_en_o, out_on_o}, exp_cmd, "R4", "register held during shifting");
      chk(sdo_oe_o, 1'b1, "R3", "data out enabled while selected");
      csn_i = 1'b1;
      tick(2 * HP);
      exp_cmd = 16'h1248;
      chk({ol_en_o, out_on_o}, exp_cmd, "R4", "register updated at chip select rise");
      chk(got[15:0], 16'h00FF, "R6", "all faults reported");

      // 32-bit loopback: daisy-chain behaviour
      tag = "R7";
      fault_i = 8'h81;
      send({480'h0, 16'h1234, 16'h0F0F}, 32, 1'b1, got);
      chk(got[31:16], 16'h0081, "R6", "status in first half");
      chk(got[15:0], 16'h1234, "R7", "second half echoes first half sent");
      exp_cmd = 16'h0F0F;
      chk({ol_en_o, out_on_o}, exp_cmd, "R7", "last 16 bits committed");

      // illegal lengths
      tag = "R5";
      send(512'hFFFF, 15, 1'b1, got);
      chk({ol_en_o, out_on_o}, exp_cmd, "R5", "15 pulses discarded");
      send(512'h1FFFF, 17, 1'b1, got);
      chk({ol_en_o, out_on_o}, exp_cmd, "R5", "17 pulses discarded");
      send(512'hFF, 8, 1'b1, got);
      chk({ol_en_o, out_on_o}, exp_cmd, "R5", "8 pulses discarded");
      send(512'h7FFFFF, 23, 1'b1, got);
      chk({ol_en_o, out_on_o}, exp_cmd, "R5", "23 pulses discarded");
      send(512'hAB6699, 24, 1'b1, got);
      exp_cmd = 16'h6699;
      chk({ol_en_o, out_on_o}, exp_cmd, "R5", "24 pulses committed");

      // deselected activity is ignored
      tag = "R3";
      fault_i = 8'h55;
      for (int i = 0; i < 20; i++) begin
         sdi_i = i[0];
         sck_i = ~sck_i;
         tick(3);
         chk(sdo_oe_o, 1'b0, "R3", "data out disabled while deselected");
         chk(sdo_o, 1'b0, "R3", "data out low while deselected");
      end
      sck_i = 1'b0;
      sdi_i = 1'b0;
      tick(HP);
      chk({ol_en_o, out_on_o}, exp_cmd, "R3", "register untouched by deselected clocks");

      // very long frames
      tag = "R9";
      bits = '1;
      bits[15:0] = 16'hC3A5;
      send(bits, 264, 1'b1, got);
      exp_cmd = 16'hC3A5;
      chk({ol_en_o, out_on_o}, exp_cmd, "R9", "264 pulses committed");
      bits[15:0] = 16'h5A5A;
      send(bits, 265, 1'b1, got);
      chk({ol_en_o, out_on_o}, exp_cmd, "R9", "265 pulses discarded");

      // sleep handling
      tag = "R8";
      sleep_i = 1'b1;
      tick(1);
      sleep_i = 1'b0;
      tick(2);
      exp_cmd = 16'h0000;
      chk({ol_en_o, out_on_o}, exp_cmd, "R8", "sleep clears register");
      send(512'h7E81, 16, 1'b0, got);
      sleep_i = 1'b1;
      tick(1);
      sleep_i = 1'b0;
      tick(2);
      csn_i = 1'b1;
      tick(2 * HP);
      chk({ol_en_o, out_on_o}, exp_cmd, "R8", "frame voided by sleep");
      send(512'h7E81, 16, 1'b1, got);
      exp_cmd = 16'h7E81;
      chk({ol_en_o, out_on_o}, exp_cmd, "R1", "commit after sleep");

      tick(4);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule